// File: doc/BRIEF.md
# Embedded Operation Polling Status Generator

This block builds the word a flash-style memory returns on a read while an internal program or erase is running or is held in suspend. Software polls this word to find out when the operation has finished. It is driven by a busy flag, an operation-type flag, the data word being programmed, the read address and the number of the sector whose erase is suspended. When no operation is busy, the array data passes straight through.

Three polling indicators are merged into one status word. The first is an inverted copy of the programmed data's top polled bit. The second is a bit that inverts on every read while the operation runs. The third inverts only on reads of the suspended sector. The block also owns the erase-suspend handshake. A suspend command takes effect only after a configurable number of clock cycles, which models the time the array needs to halt. A resume command, or the end of the operation, releases the suspend.

Top module: `flash_poll_status`

## Requirements
- R1: While `op_busy` is low, `rd_data` equals `arr_data` in the same cycle, and `suspended` is low one cycle after `op_busy` is seen low.
- R2: A read strobe is a rising edge of `rd_oe` while `rd_ce` is high, detected at the clock edge. Holding `rd_oe` high gives no further strobes. An `rd_oe` pulse with `rd_ce` low is not a strobe.
- R3: While busy and not suspended, every read returns the status word. Bit 6 holds a toggle value that inverts at each strobe. Bit 2 shows the held sector-toggle value. All bits other than 7, 6 and 2 read 0.
- R4: While a program is busy (`op_is_erase` low), bit 7 of the status word is the inverse of `last_data[7]`.
- R5: While an erase is busy and not suspended, bit 7 of the status word reads 0.
- R6: When `op_busy` is low, the bit-6 toggle value does not change. The next busy read inverts it relative to the last busy read.
- R7: `susp_cmd` is accepted only while an erase is busy and running; during a program it has no effect. Once the command is sampled, `suspended` rises exactly `SUSP_LAT` clock edges later. Bit 6 keeps toggling until then.
- R8: While suspended, a read whose sector (`rd_addr[AW-1 -: SW]`) equals `susp_sector` returns the status word with bit 7 = 0 and bit 6 frozen. Bit 2 inverts at each such strobe.
- R9: While suspended, reads of any other sector return `arr_data` and change neither toggle value.
- R10: `resume_cmd` while suspended clears `suspended` at the next edge, and bit 6 toggles again. Dropping `op_busy` also clears `suspended`.
- R11: After reset, `suspended` is low, both toggle values are 0 and the previous `rd_oe` level is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_ce | input | 1 | Chip enable for reads, active high |
| rd_oe | input | 1 | Output enable level; its rising edge marks a read |
| rd_addr | input | AW | Read address; the top SW bits give the sector |
| arr_data | input | DW | Array data at `rd_addr` |
| op_busy | input | 1 | An embedded program or erase is in progress |
| op_is_erase | input | 1 | 1 = erase in progress, 0 = program |
| last_data | input | DW | Data word most recently loaded for programming |
| susp_cmd | input | 1 | One-cycle erase-suspend request |
| resume_cmd | input | 1 | One-cycle erase-resume request |
| susp_sector | input | SW | Sector whose erase is being suspended |
| rd_data | output | DW | Read data: status word or array data |
| suspended | output | 1 | Erase is held in suspend |

## Verification
The assertions check the following on every cycle:
- array data passes through while idle;
- bit 7 takes the right polled value for program and for erase;
- bit 6 holds while idle;
- bit 2 holds outside suspend and on other sectors;
- a held output enable gives only one strobe;
- a suspend can only be reached through the entry phase.

Only the bench scenarios can show the rest:
- the exact suspend latency in cycles;
- that successive polled reads really alternate;
- that a read of another sector between two suspended-sector reads leaves exactly one inversion;
- that toggling resumes after a resume command.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_ENTER = 2'd1,
        PH_HELD  = 2'd2
    } phase_e;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
    localparam int STGL_BIT = 2;
endpackage

// File: rtl/fsg_read_strobe.sv
module fsg_read_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic oe,
    output logic strobe
);
    typedef struct packed {
        logic oe_seen;
    } strobe_st_t;

    strobe_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.oe_seen = oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = ce & oe & ~st_q.oe_seen;

    // R2: a level held high never strobes twice in a row
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/fsg_suspend_ctl.sv
module fsg_suspend_ctl #(
    parameter int SUSP_LAT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic is_erase,
    input  logic susp_cmd,
    input  logic resume_cmd,
    output logic suspended
);
    import fsg_pkg::*;

    localparam int CW = $clog2(SUSP_LAT) + 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(SUSP_LAT - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } susp_st_t;

    susp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.ph  = PH_RUN;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_RUN: begin
                    if (susp_cmd && is_erase) begin
                        st_d.ph  = PH_ENTER;
                        st_d.cnt = '0;
                    end
                end
                PH_ENTER: begin
                    if (st_q.cnt == LAST_CNT) st_d.ph = PH_HELD;
                    else                      st_d.cnt = st_q.cnt + 1'b1;
                end
                PH_HELD: begin
                    if (resume_cmd) st_d.ph = PH_RUN;
                end
                default: st_d.ph = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_RUN, cnt: '0};
        else        st_q <= st_d;
    end

    assign suspended = (st_q.ph == PH_HELD);

    // R10: dropping busy always releases the suspend
    a_r10_busy_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !suspended);
    // R7: a suspend command during a program is ignored
    a_r7_program_stays_running: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && !is_erase) |=> st_q.ph == PH_RUN);
    // R7: the held phase is reached only through the entry phase
    a_r7_held_via_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(st_q.ph == PH_ENTER));
endmodule

// File: rtl/fsg_toggle_bits.sv
module fsg_toggle_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic busy,
    input  logic suspended,
    input  logic sector_hit,
    output logic tgl_run,
    output logic tgl_sect
);
    typedef struct packed {
        logic run;
        logic sect;
    } tgl_st_t;

    tgl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe && busy) begin
            if (!suspended)      st_d.run  = ~st_q.run;
            else if (sector_hit) st_d.sect = ~st_q.sect;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgl_run  = st_q.run;
    assign tgl_sect = st_q.sect;

    // R6: no bit-6 activity while idle
    a_r6_run_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tgl_run));
    // R3: every strobe in a running operation inverts bit 6
    a_r3_run_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && busy && !suspended) |=> (tgl_run != $past(tgl_run)));
    // R8: bit 2 changes only while suspended
    a_r8_sect_hold_unsuspended: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended |=> $stable(tgl_sect));
    // R9: reads of other sectors leave bit 2 alone
    a_r9_sect_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
        !sector_hit |=> $stable(tgl_sect));
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int SW       = 6,
    parameter int SUSP_LAT = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ce,
    input  logic          rd_oe,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          op_busy,
    input  logic          op_is_erase,
    input  logic [DW-1:0] last_data,
    input  logic          susp_cmd,
    input  logic          resume_cmd,
    input  logic [SW-1:0] susp_sector,
    output logic [DW-1:0] rd_data,
    output logic          suspended
);
    import fsg_pkg::*;

    localparam int LOW_AW = AW - SW;

    logic          strobe;
    logic          tgl_run, tgl_sect;
    logic          sector_hit;
    logic          poll_bit;
    logic          show_status;
    logic [DW-1:0] status_word;
    logic [SW-1:0] rd_sector;
    logic          unused_bits;

    assign rd_sector   = rd_addr[AW-1 -: SW];
    assign sector_hit  = (rd_sector == susp_sector);
    assign unused_bits = ^{rd_addr[LOW_AW-1:0], last_data[DW-1:POLL_BIT+1], last_data[POLL_BIT-1:0]};

    fsg_read_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (rd_ce),
        .oe     (rd_oe),
        .strobe (strobe)
    );

    fsg_suspend_ctl #(.SUSP_LAT(SUSP_LAT)) u_susp (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (op_busy),
        .is_erase   (op_is_erase),
        .susp_cmd   (susp_cmd),
        .resume_cmd (resume_cmd),
        .suspended  (suspended)
    );

    fsg_toggle_bits u_tgl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .busy       (op_busy),
        .suspended  (suspended),
        .sector_hit (sector_hit),
        .tgl_run    (tgl_run),
        .tgl_sect   (tgl_sect)
    );

    assign poll_bit    = (op_is_erase || suspended) ? 1'b0 : ~last_data[POLL_BIT];
    assign show_status = op_busy && (!suspended || sector_hit);

    for (genvar b = 0; b < DW; b++) begin : g_status
        if (b == POLL_BIT) begin : g_poll
            assign status_word[b] = poll_bit;
        end else if (b == TGL_BIT) begin : g_run
            assign status_word[b] = tgl_run;
        end else if (b == STGL_BIT) begin : g_sect
            assign status_word[b] = tgl_sect;
        end else begin : g_zero
            assign status_word[b] = 1'b0;
        end
    end

    assign rd_data = show_status ? status_word : arr_data;

    // R1: idle reads are transparent
    a_r1_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> rd_data == arr_data);
    // R4: program polling shows the inverted data bit
    a_r4_program_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !op_is_erase && !suspended) |-> rd_data[POLL_BIT] == ~last_data[POLL_BIT]);
    // R5: erase polling reads 0 on the polled bit
    a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && op_is_erase && !suspended) |-> rd_data[POLL_BIT] == 1'b0);
    // R9: other sectors read true data during suspend
    a_r9_other_sector_data: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && suspended && !sector_hit) |-> rd_data == arr_data);
endmodule

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;
    localparam int AW = 12, DW = 16, SW = 3, LAT = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_ce = 0, rd_oe = 0, op_busy = 0, op_is_erase = 0, susp_cmd = 0, resume_cmd = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data, last_data = '0, rd_data;
    logic [SW-1:0] susp_sector = 3'd5;
    logic suspended;
    int n_chk = 0, n_err = 0;

    assign arr_data = {rd_addr[7:0], ~rd_addr[11:4]};
    always #5 clk = ~clk;

    flash_poll_status #(.AW(AW), .DW(DW), .SW(SW), .SUSP_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .rd_ce(rd_ce), .rd_oe(rd_oe), .rd_addr(rd_addr),
        .arr_data(arr_data), .op_busy(op_busy), .op_is_erase(op_is_erase),
        .last_data(last_data), .susp_cmd(susp_cmd), .resume_cmd(resume_cmd),
        .susp_sector(susp_sector), .rd_data(rd_data), .suspended(suspended));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 running, 1 entering, 2 held
    bit m_run, m_sect, m_oe_prev;
    int m_ph, m_cnt;

    function automatic logic [DW-1:0] m_word(input bit poll);
        logic [DW-1:0] w = '0;
        w[7] = poll; w[6] = m_run; w[2] = m_sect;
        return w;
    endfunction

    always @(posedge clk) begin
        bit stb, hit;
        logic [DW-1:0] exp;
        string tag;
        if (!rst_n) begin
            m_run = 0; m_sect = 0; m_oe_prev = 0; m_ph = 0; m_cnt = 0;
        end else begin
            stb = rd_ce && rd_oe && !m_oe_prev;
            hit = (rd_addr[11:9] == susp_sector);
            if (stb && op_busy && m_ph != 2) m_run = !m_run;
            if (stb && op_busy && m_ph == 2 && hit) m_sect = !m_sect;
            m_oe_prev = rd_oe;
            if (!op_busy) begin m_ph = 0; m_cnt = 0; end
            else if (m_ph == 0) begin if (susp_cmd && op_is_erase) begin m_ph = 1; m_cnt = 0; end end
            else if (m_ph == 1) begin if (m_cnt == LAT - 1) m_ph = 2; else m_cnt++; end
            else if (resume_cmd) m_ph = 0;
        end
        #2;
        if (!op_busy) begin exp = arr_data; tag = "R1"; end
        else if (m_ph == 2) begin
            if (rd_addr[11:9] == susp_sector) begin exp = m_word(1'b0); tag = "R8"; end
            else begin exp = arr_data; tag = "R9"; end
        end else if (op_is_erase) begin exp = m_word(1'b0); tag = "R5"; end
        else begin exp = m_word(!last_data[7]); tag = "R4"; end
        chk(rd_data == exp, tag, rd_data, exp);
        chk(suspended == (m_ph == 2), "R7", suspended, (m_ph == 2));
    end

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk); rd_addr = a; rd_ce = 1; rd_oe = 1;
        @(posedge clk); #3; v = rd_data;
        @(negedge clk); rd_oe = 0; rd_ce = 0;
    endtask

    task automatic pulse_susp();
        @(negedge clk); susp_cmd = 1; @(negedge clk); susp_cmd = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DW-1:0] v1, v2, v3, a, b, c, d, e, g1, g2, g3, h;
        int n;
        repeat (3) @(negedge clk);
        chk(suspended == 0, "R11", suspended, 0);
        chk(rd_data == arr_data, "R11", rd_data, arr_data);
        rst_n = 1;
        // idle reads pass through
        rd(12'h123, v1); chk(v1 == 16'h23ED, "R1", v1, 16'h23ED);
        rd(12'h456, v1); chk(v1 == 16'h56BA, "R1", v1, 16'h56BA);
        // program polling
        last_data = 16'h0080; op_is_erase = 0;
        @(negedge clk); op_busy = 1;
        rd(12'h010, v1); rd(12'h020, v2);
        chk(v1[6] != v2[6], "R3", v2[6], !v1[6]);
        chk(v1[7] == 0, "R4", v1[7], 0);
        chk((v1 & 16'hFF3B) == 0, "R3", v1, v1 & 16'h00C4);
        last_data = 16'h0011;
        rd(12'h030, v3); chk(v3[7] == 1, "R4", v3[7], 1);
        // held output enable gives a single strobe
        @(negedge clk); rd_ce = 1; rd_oe = 1;
        @(posedge clk); #3; a = rd_data;
        repeat (3) @(posedge clk); #3; b = rd_data;
        chk(a[6] == b[6], "R2", b[6], a[6]);
        @(negedge clk); rd_oe = 0; rd_ce = 0;
        rd(12'h040, c); chk(c[6] != b[6], "R2", c[6], !b[6]);
        @(negedge clk); rd_oe = 1; @(negedge clk); rd_oe = 0;
        rd(12'h050, d); chk(d[6] != c[6], "R2", d[6], !c[6]);
        // suspend ignored during program
        pulse_susp(); repeat (LAT + 10) @(negedge clk);
        chk(suspended == 0, "R7", suspended, 0);
        // completion: true data, toggle held
        op_busy = 0; @(negedge clk);
        chk(rd_data == arr_data, "R6", rd_data, arr_data);
        rd(12'h060, v1); rd(12'h070, v1);
        @(negedge clk); op_busy = 1;
        rd(12'h080, e); chk(e[6] != d[6], "R6", e[6], !d[6]);
        // erase polling and suspend latency
        @(negedge clk); op_busy = 0; last_data = 16'h0000;
        @(negedge clk); op_is_erase = 1; op_busy = 1;
        rd(12'h090, v1); chk(v1[7] == 0, "R5", v1[7], 0);
        pulse_susp();
        n = 0;
        for (int i = 0; i < 100 && !suspended; i++) begin @(posedge clk); #1; n++; end
        chk(n == LAT, "R7", n, LAT);
        // suspended sector reads toggle bit 2
        rd(12'hA10, g1); rd(12'hA20, g2);
        chk(g1[2] != g2[2], "R8", g2[2], !g1[2]);
        chk(g1[6] == g2[6], "R8", g2[6], g1[6]);
        chk(g1[7] == 0, "R8", g1[7], 0);
        rd(12'h100, h); chk(h == 16'h00EF, "R9", h, 16'h00EF);
        rd(12'hA30, g3);
        chk(g3[2] != g2[2], "R9", g3[2], !g2[2]);
        chk(g3[6] == g2[6], "R9", g3[6], g2[6]);
        // resume and busy drop
        @(negedge clk); resume_cmd = 1; @(negedge clk); resume_cmd = 0;
        chk(suspended == 0, "R10", suspended, 0);
        rd(12'h0A0, v1); rd(12'h0B0, v2);
        chk(v1[6] != v2[6], "R10", v2[6], !v1[6]);
        pulse_susp();
        for (int i = 0; i < 100 && !suspended; i++) @(negedge clk);
        chk(suspended == 1, "R7", suspended, 1);
        op_busy = 0; @(negedge clk);
        chk(suspended == 0, "R10", suspended, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule